// File: doc/BRIEF.md
# FSK Modem Transmitter

This block generates the audio side of a 300-baud, dual-band binary FSK modem. On each pulse of a fixed-rate update strobe it emits one 8-bit sample for a PWM output stage. It then advances a 16-bit phase accumulator. The sample comes from a quarter-wave sine lookup that is addressed by the upper six phase bits.

The phase step depends on two inputs, both read only on a strobe. The data bit selects mark or space. The channel select picks the high tone pair or the low tone pair. The step tuning words assume an update rate of about 31372.5 Hz, which is a 16 MHz clock divided by 510. At that rate the high pair falls near 2025/2225 Hz and the low pair near 1070/1270 Hz.

A second 16-bit accumulator advances by a fixed step on every strobe. It produces a one-clock baud tick each time it wraps, which the surrounding logic uses to pace the data bits. The data input idles at mark (1).

Top module: `fsk_tx_core`

## Requirements
- R1: While `rst_n` is low, both accumulators clear to zero, `sample_o` reads 128 and `baud_tick_o` is 0. The first strobe after reset therefore outputs the sample for phase 0, which is 128.
- R2: On a strobe, `sample_o` takes the table value addressed by bits [15:10] of the phase as it stood before that strobe's advance. The new value is visible one clock after the strobe.
- R3: With `answer_mode`=1, a strobe adds 4648 to the phase when `data_bit`=1 (mark) and 4230 when `data_bit`=0 (space), wrapping modulo 65536.
- R4: With `answer_mode`=0, a strobe adds 2653 to the phase for mark and 2235 for space, wrapping modulo 65536.
- R5: Table entry k (k = 0..63) equals 128 + round(127·sin(2πk/64)). Entry 16 is 255, entry 48 is 1, and no entry is 0.
- R6: Each strobe adds 627 to the baud accumulator. `baud_tick_o` is 1 for exactly the one clock after a strobe whose new accumulator value is below 627. After n strobes from reset, floor(627·n/65536) ticks have occurred.
- R7: Without a strobe, the phase, `sample_o` and the baud accumulator hold, and `baud_tick_o` is 0. Changes on `data_bit` or `answer_mode` between strobes have no effect.
- R8: Changing `data_bit` or `answer_mode` alters only the step. The phase carries on from its current value, so the waveform stays continuous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | One-clock update strobe at the sample rate |
| data_bit | input | 1 | Bit to send: 1 mark, 0 space |
| answer_mode | input | 1 | 1 selects the high tone pair, 0 the low pair |
| sample_o | output | 8 | Sine sample for the PWM stage |
| baud_tick_o | output | 1 | One-clock pulse when the baud accumulator wraps |

## Verification
The hardest behaviour to reach is the baud wrap. It occurs only about once every 104.5 strobes, and the tick must align to the exact strobe that crosses the wrap. The bench reaches it with a long, unbroken run of strobes after reset. It tracks the baud accumulator arithmetically and compares the total tick count with the closed-form value.

A second difficulty is keeping the phase continuous across mark/space and channel switches. The stimulus table switches mid-stream without resetting and tracks the phase independently. Between strobes it toggles the data and channel inputs to show they are ignored.

// File: rtl/fsk_tx_pkg.sv
package fsk_tx_pkg;
    localparam int PH_W   = 16;
    localparam int LUT_AW = 6;
    localparam int SMP_W  = 8;
    localparam int BAUD_W = 16;

    localparam logic [PH_W-1:0]   STEP_HI_SPACE = 16'd4230;
    localparam logic [PH_W-1:0]   STEP_HI_MARK  = 16'd4648;
    localparam logic [PH_W-1:0]   STEP_LO_SPACE = 16'd2235;
    localparam logic [PH_W-1:0]   STEP_LO_MARK  = 16'd2653;
    localparam logic [BAUD_W-1:0] BAUD_STEP     = 16'd627;

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [SMP_W-1:0] sample;
    } tone_st_t;

    typedef struct packed {
        logic [BAUD_W-1:0] acc;
        logic              tick;
    } baud_st_t;
endpackage

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut
    import fsk_tx_pkg::*;
(
    input  logic [LUT_AW-1:0] addr_i,
    output logic [SMP_W-1:0]  data_o
);
    localparam int QW  = LUT_AW - 1;
    localparam int QTR = 1 << (LUT_AW - 2);
    localparam logic [SMP_W-1:0] MID = SMP_W'(1 << (SMP_W - 1));

    // rising quarter of the wave, amplitude 127
    function automatic logic [SMP_W-1:0] quarter(input logic [QW-1:0] k);
        case (k)
            5'd0:  quarter = 8'd0;
            5'd1:  quarter = 8'd12;
            5'd2:  quarter = 8'd25;
            5'd3:  quarter = 8'd37;
            5'd4:  quarter = 8'd49;
            5'd5:  quarter = 8'd60;
            5'd6:  quarter = 8'd71;
            5'd7:  quarter = 8'd81;
            5'd8:  quarter = 8'd90;
            5'd9:  quarter = 8'd98;
            5'd10: quarter = 8'd106;
            5'd11: quarter = 8'd112;
            5'd12: quarter = 8'd117;
            5'd13: quarter = 8'd122;
            5'd14: quarter = 8'd125;
            5'd15: quarter = 8'd126;
            5'd16: quarter = 8'd127;
            default: quarter = 8'd0;
        endcase
    endfunction

    logic [1:0]       quad;
    logic [QW-1:0]    kk;
    logic [SMP_W-1:0] mag;

    always_comb begin
        quad = addr_i[LUT_AW-1 -: 2];
        kk   = {1'b0, addr_i[LUT_AW-3:0]};
        if (quad[0]) kk = QW'(QTR) - kk;
        mag    = quarter(kk);
        data_o = quad[1] ? (MID - mag) : (MID + mag);
    end
endmodule

// File: rtl/fsk_tune_sel.sv
module fsk_tune_sel
    import fsk_tx_pkg::*;
(
    input  logic            mark_i,
    input  logic            answer_i,
    output logic [PH_W-1:0] step_o
);
    always_comb begin
        case ({answer_i, mark_i})
            2'b11:   step_o = STEP_HI_MARK;
            2'b10:   step_o = STEP_HI_SPACE;
            2'b01:   step_o = STEP_LO_MARK;
            default: step_o = STEP_LO_SPACE;
        endcase
    end
endmodule

// File: rtl/fsk_baud_pacer.sv
module fsk_baud_pacer
    import fsk_tx_pkg::*;
#(
    parameter logic [BAUD_W-1:0] STEP = BAUD_STEP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    output logic tick_o
);
    baud_st_t          baud_d, baud_q;
    logic [BAUD_W-1:0] sum;

    always_comb begin
        sum         = baud_q.acc + STEP;
        baud_d      = baud_q;
        baud_d.tick = 1'b0;
        if (stb_i) begin
            baud_d.acc  = sum;
            baud_d.tick = (sum < STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) baud_q <= '0;
        else        baud_q <= baud_d;
    end

    assign tick_o = baud_q.tick;
endmodule

// File: rtl/fsk_tx_core.sv
module fsk_tx_core
    import fsk_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_stb,
    input  logic             data_bit,
    input  logic             answer_mode,
    output logic [SMP_W-1:0] sample_o,
    output logic             baud_tick_o
);
    localparam logic [SMP_W-1:0] MID = SMP_W'(1 << (SMP_W - 1));

    tone_st_t         tone_d, tone_q;
    logic [PH_W-1:0]  step;
    logic [SMP_W-1:0] lut_val;
    logic [PH_W-1:0]  phase_q;

    fsk_tune_sel u_sel (
        .mark_i  (data_bit),
        .answer_i(answer_mode),
        .step_o  (step)
    );

    fsk_sine_lut u_lut (
        .addr_i(tone_q.phase[PH_W-1 -: LUT_AW]),
        .data_o(lut_val)
    );

    fsk_baud_pacer #(.STEP(BAUD_STEP)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (upd_stb),
        .tick_o(baud_tick_o)
    );

    always_comb begin
        tone_d = tone_q;
        if (upd_stb) begin
            tone_d.sample = lut_val;
            tone_d.phase  = tone_q.phase + step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_q.phase  <= '0;
            tone_q.sample <= MID;
        end else begin
            tone_q <= tone_d;
        end
    end

    assign sample_o = tone_q.sample;
    assign phase_q  = tone_q.phase;
endmodule

// File: rtl/fsk_tx_core_chk.sv
module fsk_tx_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_stb,
    input logic        data_bit,
    input logic        answer_mode,
    input logic [7:0]  sample_o,
    input logic        baud_tick_o,
    input logic [15:0] phase_q
);
    // R3
    hi_mark_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && answer_mode && data_bit) |=> (phase_q == 16'($past(phase_q) + 16'd4648)));
    // R3
    hi_space_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && answer_mode && !data_bit) |=> (phase_q == 16'($past(phase_q) + 16'd4230)));
    // R4
    lo_mark_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && !answer_mode && data_bit) |=> (phase_q == 16'($past(phase_q) + 16'd2653)));
    // R4
    lo_space_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && !answer_mode && !data_bit) |=> (phase_q == 16'($past(phase_q) + 16'd2235)));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |=> ($stable(phase_q) && $stable(sample_o) && !baud_tick_o));
    // R6
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick_o |=> !baud_tick_o);
    // R6
    tick_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick_o |-> $past(upd_stb));
    // R5
    sample_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o != 8'd0);
endmodule

bind fsk_tx_core fsk_tx_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_stb    (upd_stb),
    .data_bit   (data_bit),
    .answer_mode(answer_mode),
    .sample_o   (sample_o),
    .baud_tick_o(baud_tick_o),
    .phase_q    (phase_q)
);

// File: tb/fsk_tx_core_test.sv
module fsk_tx_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_stb = 1'b0;
    logic       data_bit = 1'b1;
    logic       answer_mode = 1'b0;
    logic [7:0] sample_o;
    logic       baud_tick_o;

    always #2 clk = ~clk;

    fsk_tx_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_stb    (upd_stb),
        .data_bit   (data_bit),
        .answer_mode(answer_mode),
        .sample_o   (sample_o),
        .baud_tick_o(baud_tick_o)
    );

    typedef struct packed {
        logic       d;
        logic       m;
        logic [9:0] n;
        logic [3:0] gap;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b1, 10'd40, 4'd0},
        '{1'b0, 1'b1, 10'd40, 4'd1},
        '{1'b1, 1'b0, 10'd40, 4'd0},
        '{1'b0, 1'b0, 10'd40, 4'd2},
        '{1'b1, 1'b1, 10'd7,  4'd3},
        '{1'b0, 1'b0, 10'd9,  4'd0},
        '{1'b1, 1'b0, 10'd13, 4'd1},
        '{1'b0, 1'b1, 10'd11, 4'd0}
    };

    int          n_vec = 0;
    int          n_bad = 0;
    int          n_ticks = 0;
    logic [15:0] exp_phase = '0;
    logic [15:0] exp_baud = '0;

    function automatic logic [7:0] ref_sine(input int k);
        real s;
        s = $sin(2.0 * 3.14159265358979 * real'(k) / 64.0);
        return 8'($rtoi(128.0 + 127.0 * s + 0.5));
    endfunction

    function automatic logic [15:0] ref_step(input logic d, input logic m);
        if (m) return d ? 16'd4648 : 16'd4230;
        return d ? 16'd2653 : 16'd2235;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic d, input logic m, input string tag);
        logic [15:0] nb;
        logic        et;
        @(negedge clk);
        data_bit = d; answer_mode = m; upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        nb = exp_baud + 16'd627;
        et = (nb < 16'd627);
        check({tag, " R2 sample"}, int'(sample_o), int'(ref_sine(int'(exp_phase[15:10]))));
        check("R6 tick", int'(baud_tick_o), int'(et));
        if (baud_tick_o) n_ticks++;
        exp_phase = exp_phase + ref_step(d, m);
        exp_baud  = nb;
    endtask

    task automatic idle(input int n);
        logic [7:0] held;
        for (int i = 0; i < n; i++) begin
            held = sample_o;
            @(negedge clk);
            data_bit = ~data_bit; answer_mode = ~answer_mode;
            @(negedge clk);
            check("R7 hold sample", int'(sample_o), int'(held));
            check("R7 tick low", int'(baud_tick_o), 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; upd_stb = 1'b0; data_bit = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset sample", int'(sample_o), 128);
        check("R1 reset tick", int'(baud_tick_o), 0);
        rst_n = 1'b1;
        exp_phase = '0; exp_baud = '0; n_ticks = 0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: first strobe reads phase 0
        strobe(1'b1, 1'b1, "R1");
        check("R1 first sample", int'(sample_o), 128);

        // table walk, mixed channel and bit switches without phase reset (R8)
        for (int v = 0; v < 8; v++) begin
            for (int k = 0; k < int'(VECS[v].n); k++) begin
                if (k == 0) strobe(VECS[v].d, VECS[v].m, "R8");
                else if (VECS[v].m) strobe(VECS[v].d, VECS[v].m, "R3");
                else strobe(VECS[v].d, VECS[v].m, "R4");
                idle(int'(VECS[v].gap));
            end
        end

        // R5: extreme table entries, direct from reference
        check("R5 peak entry", int'(ref_sine(16)), 255);
        check("R5 trough entry", int'(ref_sine(48)), 1);

        // R6: long back-to-back run from reset, tick count in closed form
        do_reset();
        for (int i = 0; i < 600; i++) strobe(1'b0, 1'b0, "R5");
        check("R6 tick count", n_ticks, (627 * 600) / 65536);
        idle(2);

        // R1: reset mid-stream returns to phase 0
        do_reset();
        strobe(1'b0, 1'b1, "R1");
        check("R1 restart sample", int'(sample_o), 128);
        strobe(1'b0, 1'b1, "R3");
        check("R3 second sample", int'(sample_o), int'(ref_sine(4230 >> 10)));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule